// File: doc/BRIEF.md
# Register-Driven Byte Flash Access Engine

This block lets a host reach an external byte-wide parallel flash or EEPROM through two words of a small 32-bit register window, not through a memory-mapped aperture. One word carries the target byte address, the transfer direction and a start/busy flag. The other word carries the byte to be written or the byte that was read back.

Software first polls the busy flag until it is clear. It then loads the data word (for a write) and writes the command word with the address, the direction and the start flag set. The engine runs exactly one strobed cycle on the flash pins. The cycle is one setup cycle, then a strobe of a fixed number of clocks, then one hold cycle. After that the flag drops. For a read, the captured byte is already in the data word by the time software sees the flag clear.

The flash data bus is brought out as separate input, output and output-enable signals, so the chip's pad ring can build the tristate buffer.

Top module: `flash_access_engine`

## Requirements
- R1: After the active-low synchronous reset, both register words read zero, chip enable, output enable and write enable are all high (inactive), and the data bus output enable is 0.
- R2: The command word at offset 0x50 holds the byte address in bits [18:0], the direction in bit 24 (1 = read from flash, 0 = write to flash) and the start/busy flag in bit 25. The data word at offset 0x54 holds the byte in bits [7:0]. All other bits of both words, and every other offset, read as zero and ignore writes.
- R3: Writing the command word with bit 25 set while idle starts one cycle. Bit 25 then reads 1 for exactly ACC_CYCLES+2 clock cycles and returns to 0 on its own.
- R4: During a write cycle, chip enable is low for ACC_CYCLES+2 cycles and write enable is low for ACC_CYCLES cycles in the middle of them. Output enable stays high. The data bus is driven with data word bits [7:0] for the whole time chip enable is low.
- R5: During a read cycle, output enable is low for ACC_CYCLES cycles and write enable stays high. The data bus is not driven. The flash byte present in the last output-enable cycle is stored in data word bits [7:0].
- R6: A command-word write while busy changes neither the address nor the direction, and it does not start a second cycle.
- R7: A data-word write while busy is ignored, so the byte driven to the flash and the stored data word are unaffected.
- R8: The flash address pins equal the programmed address and stay stable while chip enable is low, across the full 19-bit range including 0x7FFFF.
- R9: Output enable and write enable are never low at the same time, and neither is low while chip enable is high.
- R10: Whenever the engine is idle (busy flag clear), chip enable is high and the data bus is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | REG_AW | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| flash_addr | output | ADDR_W | Flash byte address |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| flash_oe_n | output | 1 | Flash output enable, active low |
| flash_we_n | output | 1 | Flash write enable, active low |
| flash_dq_o | output | 8 | Byte driven toward the flash |
| flash_dq_oe | output | 1 | 1 when the engine drives the flash data bus |
| flash_dq_i | input | 8 | Byte received from the flash |

## Verification
The embedded properties watch the pin discipline on every cycle: the two strobes never overlap, no strobe appears outside chip enable, the address does not move inside a cycle, the bus is never driven during a read or while idle, and the address, direction and stored byte do not move under writes that arrive while busy. Only the bench scenarios can show that the data actually reaches the flash model and comes back. They also show that the busy window and the strobe width have the exact lengths, that the extreme address 0x7FFFF works, that bits outside the defined fields read as zero, and that a start issued while busy produces no second cycle.

// File: rtl/flash_eng_pkg.sv
package flash_eng_pkg;

    // Command word field positions
    localparam int CMD_DIR_BIT  = 24;
    localparam int CMD_BUSY_BIT = 25;

    // Flash data path width
    localparam int FL_DW = 8;

    // Phases of one flash access
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } fe_phase_e;

endpackage

// File: rtl/fe_regfile.sv
module fe_regfile
    import flash_eng_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int REG_AW   = 8,
    parameter int CMD_OFS  = 'h50,
    parameter int DATA_OFS = 'h54
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              cyc_done,
    input  logic              cyc_sample,
    input  logic [FL_DW-1:0]  flash_byte,
    output logic              go,
    output logic              busy,
    output logic              dir_rd,
    output logic [ADDR_W-1:0] addr,
    output logic [FL_DW-1:0]  wr_byte
);

    localparam logic [REG_AW-1:0] CMD_SEL  = REG_AW'(CMD_OFS);
    localparam logic [REG_AW-1:0] DATA_SEL = REG_AW'(DATA_OFS);

    typedef struct packed {
        logic              busy;
        logic              dir_rd;
        logic [ADDR_W-1:0] addr;
        logic [FL_DW-1:0]  data;
    } rf_t;

    rf_t  rf_q, rf_d;
    logic cmd_hit, data_hit;

    assign cmd_hit  = bus_we && (bus_addr == CMD_SEL);
    assign data_hit = bus_we && (bus_addr == DATA_SEL);

    always_comb begin
        rf_d = rf_q;
        go   = 1'b0;
        if (!rf_q.busy) begin
            if (cmd_hit) begin
                rf_d.addr   = bus_wdata[ADDR_W-1:0];
                rf_d.dir_rd = bus_wdata[CMD_DIR_BIT];
                if (bus_wdata[CMD_BUSY_BIT]) begin
                    rf_d.busy = 1'b1;
                    go        = 1'b1;
                end
            end
            if (data_hit) begin
                rf_d.data = bus_wdata[FL_DW-1:0];
            end
        end else begin
            if (cyc_sample) begin
                rf_d.data = flash_byte;
            end
            if (cyc_done) begin
                rf_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CMD_SEL) begin
            bus_rdata[ADDR_W-1:0]   = rf_q.addr;
            bus_rdata[CMD_DIR_BIT]  = rf_q.dir_rd;
            bus_rdata[CMD_BUSY_BIT] = rf_q.busy;
        end else if (bus_addr == DATA_SEL) begin
            bus_rdata[FL_DW-1:0] = rf_q.data;
        end
    end

    assign busy    = rf_q.busy;
    assign dir_rd  = rf_q.dir_rd;
    assign addr    = rf_q.addr;
    assign wr_byte = rf_q.data;

    // R6
    cmd_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_q.busy && cmd_hit) |=> ($stable(rf_q.addr) && $stable(rf_q.dir_rd)));

    // R7
    data_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_q.busy && data_hit && !cyc_sample) |=> $stable(rf_q.data));

    // R3
    busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rf_q.busy) |-> $past(cmd_hit && bus_wdata[CMD_BUSY_BIT]));

    // R5
    sample_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_sample |-> (rf_q.busy && rf_q.dir_rd));

endmodule

// File: rtl/fe_cycle_ctrl.sv
module fe_cycle_ctrl
    import flash_eng_pkg::*;
#(
    parameter int ACC_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic dir_rd,
    output logic cyc_done,
    output logic cyc_sample,
    output logic ce_n,
    output logic oe_n,
    output logic we_n,
    output logic dq_oe
);

    localparam int               CNT_W = $clog2(ACC_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(ACC_CYCLES - 1);

    typedef struct packed {
        fe_phase_e        ph;
        logic [CNT_W-1:0] cnt;
    } cc_t;

    cc_t cc_q, cc_d;

    always_comb begin
        cc_d = cc_q;
        unique case (cc_q.ph)
            PH_IDLE: begin
                if (go) begin
                    cc_d.ph  = PH_SETUP;
                    cc_d.cnt = '0;
                end
            end
            PH_SETUP: begin
                cc_d.ph  = PH_STROBE;
                cc_d.cnt = '0;
            end
            PH_STROBE: begin
                if (cc_q.cnt == LAST) begin
                    cc_d.ph = PH_HOLD;
                end else begin
                    cc_d.cnt = cc_q.cnt + 1'b1;
                end
            end
            PH_HOLD: begin
                cc_d.ph = PH_IDLE;
            end
            default: cc_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cc_q <= '{ph: PH_IDLE, cnt: '0};
        end else begin
            cc_q <= cc_d;
        end
    end

    assign ce_n       = (cc_q.ph == PH_IDLE);
    assign oe_n       = !((cc_q.ph == PH_STROBE) && dir_rd);
    assign we_n       = !((cc_q.ph == PH_STROBE) && !dir_rd);
    assign dq_oe      = (cc_q.ph != PH_IDLE) && !dir_rd;
    assign cyc_done   = (cc_q.ph == PH_HOLD);
    assign cyc_sample = (cc_q.ph == PH_STROBE) && (cc_q.cnt == LAST) && dir_rd;

    // R3
    go_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (cc_q.ph == PH_IDLE));

    // R6
    dir_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && $past(!ce_n)) |-> $stable(dir_rd));

endmodule

// File: rtl/flash_access_engine.sv
module flash_access_engine
    import flash_eng_pkg::*;
#(
    parameter int ADDR_W     = 19,
    parameter int ACC_CYCLES = 4,
    parameter int REG_AW     = 8,
    parameter int CMD_OFS    = 'h50,
    parameter int DATA_OFS   = 'h54
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [ADDR_W-1:0] flash_addr,
    output logic              flash_ce_n,
    output logic              flash_oe_n,
    output logic              flash_we_n,
    output logic [7:0]        flash_dq_o,
    output logic              flash_dq_oe,
    input  logic [7:0]        flash_dq_i
);

    logic go, busy, dir_rd, cyc_done, cyc_sample;

    fe_regfile #(
        .ADDR_W   (ADDR_W),
        .REG_AW   (REG_AW),
        .CMD_OFS  (CMD_OFS),
        .DATA_OFS (DATA_OFS)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .cyc_done   (cyc_done),
        .cyc_sample (cyc_sample),
        .flash_byte (flash_dq_i),
        .go         (go),
        .busy       (busy),
        .dir_rd     (dir_rd),
        .addr       (flash_addr),
        .wr_byte    (flash_dq_o)
    );

    fe_cycle_ctrl #(
        .ACC_CYCLES (ACC_CYCLES)
    ) u_cycle (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .dir_rd     (dir_rd),
        .cyc_done   (cyc_done),
        .cyc_sample (cyc_sample),
        .ce_n       (flash_ce_n),
        .oe_n       (flash_oe_n),
        .we_n       (flash_we_n),
        .dq_oe      (flash_dq_oe)
    );

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!flash_oe_n && !flash_we_n));

    // R9
    strobe_in_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash_oe_n || !flash_we_n) |-> !flash_ce_n);

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash_ce_n && $past(!flash_ce_n)) |-> $stable(flash_addr));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (flash_ce_n && !flash_dq_oe));

    // R5
    no_drive_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_oe_n |-> !flash_dq_oe);

endmodule

// File: tb/flash_access_engine_bench.sv
`timescale 1ns/1ps
module flash_access_engine_bench;

    localparam int ACC    = 4;
    localparam int ADDR_W = 19;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_we = 1'b0;
    logic [7:0]        bus_addr = 8'h00;
    logic [31:0]       bus_wdata = 32'h0;
    logic [31:0]       bus_rdata;
    logic [ADDR_W-1:0] flash_addr;
    logic              flash_ce_n, flash_oe_n, flash_we_n, flash_dq_oe;
    logic [7:0]        flash_dq_o;
    logic [7:0]        flash_dq_i;

    int n_chk = 0;
    int n_bad = 0;
    bit armed = 1'b0;
    bit done_flag = 1'b0;

    typedef struct {
        bit                is_rd;
        logic [ADDR_W-1:0] a;
        logic [7:0]        d;
    } exp_t;

    exp_t exp_q[$];
    logic [7:0] mem [int];

    always #2.5 clk = ~clk;

    flash_access_engine #(.ADDR_W(ADDR_W), .ACC_CYCLES(ACC)) u_flash_access_engine (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flash_addr(flash_addr),
        .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n), .flash_we_n(flash_we_n),
        .flash_dq_o(flash_dq_o), .flash_dq_oe(flash_dq_oe), .flash_dq_i(flash_dq_i)
    );

    function automatic logic [7:0] model_rd(logic [ADDR_W-1:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return 8'hFF;
    endfunction

    always @(flash_ce_n or flash_oe_n or flash_addr) begin
        flash_dq_i = (!flash_ce_n && !flash_oe_n) ? model_rd(flash_addr) : 8'h00;
    end

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Monitor: each completed strobe pops one expected item
    task automatic mon_item(bit rd);
        exp_t e;
        if (exp_q.size() == 0) begin
            check(1'b0, "R6 unexpected flash cycle", {12'h0, flash_addr}, 32'h0);
            return;
        end
        e = exp_q.pop_front();
        check(e.is_rd == rd, "R4/R5 cycle kind", 32'(rd), 32'(e.is_rd));
        check(flash_addr == e.a, "R8 address at strobe end", {13'h0, flash_addr}, {13'h0, e.a});
        if (!rd) begin
            check(flash_dq_o == e.d && flash_dq_oe, "R4 write byte on bus",
                  {23'h0, flash_dq_oe, flash_dq_o}, {23'h0, 1'b1, e.d});
            mem[int'(flash_addr)] = flash_dq_o;
        end
    endtask

    always @(posedge flash_we_n) if (armed) mon_item(1'b0);
    always @(posedge flash_oe_n) if (armed) mon_item(1'b1);

    task automatic reg_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic reg_read(logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            reg_read(8'h50, v);
            if (!v[25]) return;
        end
        check(1'b0, "R3 busy never cleared", v, 32'h0);
    endtask

    function automatic logic [31:0] cmd(bit rd, logic [ADDR_W-1:0] a);
        return {6'b0, 1'b1, rd, 5'b0, a};
    endfunction

    task automatic do_write(logic [ADDR_W-1:0] a, logic [7:0] d);
        wait_idle();
        reg_write(8'h54, {24'h0, d});
        exp_q.push_back('{is_rd: 1'b0, a: a, d: d});
        reg_write(8'h50, cmd(1'b0, a));
        wait_idle();
    endtask

    task automatic do_read(logic [ADDR_W-1:0] a, logic [7:0] expd, string req);
        logic [31:0] v;
        wait_idle();
        exp_q.push_back('{is_rd: 1'b1, a: a, d: expd});
        reg_write(8'h50, cmd(1'b1, a));
        wait_idle();
        reg_read(8'h54, v);
        check(v == {24'h0, expd}, req, v, {24'h0, expd});
    endtask

    // Counts busy cycles, strobe cycles and bus-drive mismatches of one access
    task automatic measure(bit rd, logic [ADDR_W-1:0] a,
                           output int nb, output int ns, output int nce, output int bad);
        logic [31:0] v;
        nb = 0; ns = 0; nce = 0; bad = 0;
        wait_idle();
        exp_q.push_back('{is_rd: rd, a: a, d: 8'h00});
        if (!rd) exp_q[$].d = 8'h00;
        reg_write(8'h50, cmd(rd, a));
        reg_read(8'h50, v);
        while (v[25] && nb < 100) begin
            nb++;
            if (rd ? !flash_oe_n : !flash_we_n) ns++;
            if (!flash_ce_n) nce++;
            if (flash_dq_oe == rd) bad++;
            if (rd ? !flash_we_n : !flash_oe_n) bad++;
            @(negedge clk);
            reg_read(8'h50, v);
        end
    endtask

    initial begin
        int          wd;
        for (wd = 0; wd < 20000 && !done_flag; wd++) @(posedge clk);
        if (!done_flag) begin
            check(1'b0, "watchdog expired", 32'(wd), 32'h0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int nb, ns, nce, bad;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        armed = 1'b1;

        // R1 reset state
        reg_read(8'h50, v);
        check(v == 32'h0, "R1 command word after reset", v, 32'h0);
        reg_read(8'h54, v);
        check(v == 32'h0, "R1 data word after reset", v, 32'h0);
        check(flash_ce_n && flash_oe_n && flash_we_n && !flash_dq_oe, "R1 pins idle after reset",
              {28'h0, flash_ce_n, flash_oe_n, flash_we_n, flash_dq_oe}, 32'he);

        // R2 field layout and unused bits
        reg_write(8'h50, 32'hFDFF_FFFF);
        reg_read(8'h50, v);
        check(v == 32'h0107_FFFF, "R2 command word fields", v, 32'h0107_FFFF);
        check(flash_ce_n, "R2 no cycle without start bit", 32'(flash_ce_n), 32'h1);
        reg_write(8'h54, 32'hFFFF_FFA5);
        reg_read(8'h54, v);
        check(v == 32'h0000_00A5, "R2 data word fields", v, 32'hA5);
        reg_write(8'h58, 32'hFFFF_FFFF);
        reg_read(8'h58, v);
        check(v == 32'h0, "R2 unmapped offset reads zero", v, 32'h0);

        // R4 / R8 writes at several addresses including the top
        do_write(19'h00000, 8'h11);
        do_write(19'h7FFFF, 8'hE7);
        do_write(19'h40000, 8'h5A);
        do_write(19'h12345, 8'hC3);

        // R5 / R8 read-backs
        do_read(19'h7FFFF, 8'hE7, "R8 top address read-back");
        do_read(19'h00000, 8'h11, "R5 read-back at zero");
        do_read(19'h40000, 8'h5A, "R5 read-back 0x40000");
        do_read(19'h12345, 8'hC3, "R5 read-back 0x12345");
        do_read(19'h00ABC, 8'hFF, "R5 read of blank location");
        reg_read(8'h54, v);
        check(v[31:8] == 24'h0, "R2 upper data bits zero after read", v, 32'hFF);

        // R3 / R4 busy and strobe timing of a write
        reg_write(8'h54, 32'h0000_0000);
        measure(1'b0, 19'h00100, nb, ns, nce, bad);
        check(nb == ACC + 2, "R3 busy length write", 32'(nb), 32'(ACC + 2));
        check(ns == ACC, "R4 write strobe length", 32'(ns), 32'(ACC));
        check(nce == ACC + 2, "R4 chip enable length", 32'(nce), 32'(ACC + 2));
        check(bad == 0, "R4 drive and strobe discipline", 32'(bad), 32'h0);
        check(flash_ce_n && !flash_dq_oe, "R10 idle after write", 
              {30'h0, flash_ce_n, flash_dq_oe}, 32'h2);

        // R3 / R5 busy and strobe timing of a read
        measure(1'b1, 19'h00100, nb, ns, nce, bad);
        check(nb == ACC + 2, "R3 busy length read", 32'(nb), 32'(ACC + 2));
        check(ns == ACC, "R5 read strobe length", 32'(ns), 32'(ACC));
        check(bad == 0, "R5 bus released during read", 32'(bad), 32'h0);

        // R6 / R7 writes while busy are ignored
        wait_idle();
        reg_write(8'h54, 32'h0000_0096);
        exp_q.push_back('{is_rd: 1'b0, a: 19'h2AAAA, d: 8'h96});
        reg_write(8'h50, cmd(1'b0, 19'h2AAAA));
        reg_write(8'h54, 32'h0000_0033);
        reg_write(8'h50, cmd(1'b1, 19'h15555));
        wait_idle();
        repeat (ACC + 4) @(negedge clk);
        reg_read(8'h50, v);
        check(v == 32'h0002_AAAA, "R6 command word unchanged by busy write", v, 32'h0002_AAAA);
        reg_read(8'h54, v);
        check(v == 32'h96, "R7 data word unchanged by busy write", v, 32'h96);
        check(exp_q.size() == 0, "R6 exactly one cycle ran", 32'(exp_q.size()), 32'h0);
        do_read(19'h2AAAA, 8'h96, "R7 flash holds pre-busy byte");

        wait_idle();
        check(exp_q.size() == 0, "R4/R5 all expected cycles seen", 32'(exp_q.size()), 32'h0);

        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule